// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single hardware semaphore shared by up to 64 threads. It holds a 16-bit count. A read request performs the P (take) operation. A write request performs the V (post) operation. Each request carries a view code that selects how a take on an empty semaphore behaves. In the sync view the requester is told to stall, and it is remembered as a waiter. In the try view the request just comes back with zero. A post wakes every remembered waiter at once by pulsing their bits on a wake vector. The woken threads then retry their take.

A mode flag, loaded through a separate mode-write strobe, takes the cell out of semaphore service. While the flag is set, takes return zero and posts do nothing.

The cell is organised around a response state register. Every accepted request is classified into one of these states, and the state drives the outputs for exactly one cycle after the request:

- `RSP_IDLE`: no request.
- `RSP_TAKE`: a take that found a non-zero count.
- `RSP_STALL`: a sync take on an empty count.
- `RSP_DRY`: a try take on an empty count.
- `RSP_POST`: a post with no waiters.
- `RSP_POST_WAKE`: a post with waiters.
- `RSP_OFF_READ`: a take while the cell is in the non-semaphore mode.
- `RSP_OFF_WRITE`: a post while the cell is in the non-semaphore mode.

Transitions are taken on every clock edge:

- **`idle`**: any state goes to `RSP_IDLE` when there is no request.
- **`grant`**: any state goes to `RSP_TAKE`.
- **`park`**: any state goes to `RSP_STALL`.
- **`decline`**: any state goes to `RSP_DRY`.
- **`post`**: any state goes to `RSP_POST`.
- **`release`**: any state goes to `RSP_POST_WAKE`.
- **`bypass`**: any state goes to one of the `RSP_OFF_*` states.

The next state depends only on the request, the mode flag, whether the count is zero and whether any waiter is recorded.

Top module: `semaphore_cell`

## Requirements
- R1: A take answers with `rsp_valid` high one cycle after the request, and `rsp_data` equals the count as it stood before that take.
- R2: A take that finds a count above zero lowers the count by exactly one.
- R3: A take in the sync view (`req_view` = 0) on a count of zero:
  - raises `rsp_block` for one cycle;
  - returns 0;
  - records the requesting thread (bit `req_tid`) as a waiter;
  - leaves the count at zero.
- R4: A take in the try view (`req_view` = 1) on a count of zero returns 0, does not raise `rsp_block`, records no waiter and leaves the count at zero.
- R5: A post raises the count by one while it is below 0xFFFF. At 0xFFFF the count stays at 0xFFFF and never wraps.
- R6: The data carried by a post (`req_wdata`) has no effect on the count.
- R7: A post made while one or more waiters are recorded drives every recorded waiter's bit on `wake_vec` and empties the waiter set. This applies even when the count is saturated.
- R8: While the mode flag is set (by `mode_we` with `mode_fifo` = 1):
  - a take returns 0 with `rsp_valid` high and no block;
  - a post changes nothing and wakes nobody.
  - Clearing the flag restores semaphore service with the count and waiters intact.
- R9: After reset the count is 0, the mode flag is clear, no waiter is recorded, and all outputs are low.
- R10: `wake_vec`, `rsp_block` and `rsp_valid` are single-cycle pulses. They are all zero in the cycle after an idle request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_view | input | 1 | 0 = sync (stall on empty), 1 = try |
| req_write | input | 1 | 1 = post (V), 0 = take (P) |
| req_tid | input | 6 | Requesting thread number |
| req_wdata | input | 16 | Write data, ignored by the semaphore |
| mode_we | input | 1 | Load the mode flag |
| mode_fifo | input | 1 | Mode flag value; 1 takes the cell out of semaphore service |
| rsp_valid | output | 1 | Take response present |
| rsp_data | output | 16 | Count before the take (0 in the other mode) |
| rsp_block | output | 1 | Requester must stall |
| wake_vec | output | 64 | One bit per thread to wake, one-cycle pulse |

## Verification
A corrupted count appears on `rsp_data` at the next take. It can stay hidden for many cycles if only posts follow. For that reason the run interleaves takes with posts throughout, and also drives the count to saturation and reads it back.

A lost or stray waiter bit appears only on `wake_vec` at the next post. The bench therefore compares the whole wake vector on every post against a behavioural model.

A wrong response state shows within one cycle as a wrong valid, block or wake pulse. These are compared on every clock.

// File: rtl/semcell_pkg.sv
package semcell_pkg;

    localparam logic VIEW_SYNC = 1'b0;
    localparam logic VIEW_TRY  = 1'b1;

    typedef enum logic [2:0] {
        RSP_IDLE      = 3'd0,
        RSP_TAKE      = 3'd1,
        RSP_STALL     = 3'd2,
        RSP_DRY       = 3'd3,
        RSP_POST      = 3'd4,
        RSP_POST_WAKE = 3'd5,
        RSP_OFF_READ  = 3'd6,
        RSP_OFF_WRITE = 3'd7
    } rsp_e;

endpackage

// File: rtl/semcell_counter.sv
module semcell_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count   = cnt_q;
    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/semcell_waitset.sv
module semcell_waitset #(
    parameter int THREADS = 64,
    parameter int TID_W   = $clog2(THREADS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               add_en,
    input  logic [TID_W-1:0]   add_tid,
    input  logic               clr_en,
    output logic [THREADS-1:0] waiters,
    output logic               any
);
    logic [THREADS-1:0] mask_q;
    logic [THREADS-1:0] add_bit;

    always_comb begin
        add_bit = '0;
        if (add_en) begin
            add_bit = {{(THREADS-1){1'b0}}, 1'b1} << add_tid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr_en) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_q | add_bit;
        end
    end

    assign waiters = mask_q;
    assign any     = |mask_q;
endmodule

// File: rtl/semcell_classify.sv
module semcell_classify
    import semcell_pkg::*;
(
    input  logic req_valid,
    input  logic req_view,
    input  logic req_write,
    input  logic off_mode,
    input  logic cnt_zero,
    input  logic have_waiters,
    output rsp_e next_rsp
);
    always_comb begin
        next_rsp = RSP_IDLE;
        if (req_valid) begin
            unique case ({off_mode, req_write})
                2'b10:   next_rsp = RSP_OFF_READ;
                2'b11:   next_rsp = RSP_OFF_WRITE;
                2'b01:   next_rsp = have_waiters ? RSP_POST_WAKE : RSP_POST;
                default: begin
                    if (!cnt_zero) begin
                        next_rsp = RSP_TAKE;
                    end else if (req_view == VIEW_SYNC) begin
                        next_rsp = RSP_STALL;
                    end else begin
                        next_rsp = RSP_DRY;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/semaphore_cell.sv
module semaphore_cell
    import semcell_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int THREADS = 64,
    parameter int TID_W   = $clog2(THREADS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_view,
    input  logic               req_write,
    input  logic [TID_W-1:0]   req_tid,
    input  logic [CNT_W-1:0]   req_wdata,
    input  logic               mode_we,
    input  logic               mode_fifo,
    output logic               rsp_valid,
    output logic [CNT_W-1:0]   rsp_data,
    output logic               rsp_block,
    output logic [THREADS-1:0] wake_vec
);
    rsp_e               state_q;
    rsp_e               state_d;
    logic               fifo_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               cnt_zero;
    logic [THREADS-1:0] mask_q;
    logic               mask_any;
    logic [CNT_W-1:0]   data_q;
    logic [THREADS-1:0] wake_q;
    logic               do_inc;
    logic               do_dec;
    logic               do_park;
    logic               do_release;
    logic               unused_wdata;

    // Post data carries no meaning for the semaphore.
    assign unused_wdata = ^req_wdata;

    semcell_classify u_class (
        .req_valid    (req_valid),
        .req_view     (req_view),
        .req_write    (req_write),
        .off_mode     (fifo_q),
        .cnt_zero     (cnt_zero),
        .have_waiters (mask_any),
        .next_rsp     (state_d)
    );

    assign do_dec     = (state_d == RSP_TAKE);
    assign do_inc     = (state_d == RSP_POST) || (state_d == RSP_POST_WAKE);
    assign do_park    = (state_d == RSP_STALL);
    assign do_release = (state_d == RSP_POST_WAKE);

    semcell_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (do_inc),
        .dec     (do_dec),
        .count   (cnt_q),
        .is_zero (cnt_zero)
    );

    semcell_waitset #(.THREADS(THREADS), .TID_W(TID_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (do_park),
        .add_tid (req_tid),
        .clr_en  (do_release),
        .waiters (mask_q),
        .any     (mask_any)
    );

    // State register with the captured response payloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            fifo_q  <= 1'b0;
            data_q  <= '0;
            wake_q  <= '0;
        end else begin
            state_q <= state_d;
            if (mode_we) begin
                fifo_q <= mode_fifo;
            end
            if (state_d == RSP_OFF_READ) begin
                data_q <= '0;
            end else if (!req_write) begin
                data_q <= cnt_q;
            end
            wake_q <= do_release ? mask_q : '0;
        end
    end

    // Outputs decoded from the response state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_block = 1'b0;
        rsp_data  = '0;
        wake_vec  = '0;
        unique case (state_q)
            RSP_TAKE, RSP_DRY, RSP_OFF_READ: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            RSP_STALL: begin
                rsp_valid = 1'b1;
                rsp_block = 1'b1;
                rsp_data  = data_q;
            end
            RSP_POST_WAKE: wake_vec = wake_q;
            default: ;
        endcase
    end
endmodule

module semcell_checks #(
    parameter int CNT_W   = 16,
    parameter int THREADS = 64,
    parameter int TID_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TID_W-1:0]   req_tid,
    input logic               rsp_valid,
    input logic [CNT_W-1:0]   rsp_data,
    input logic               rsp_block,
    input logic [THREADS-1:0] wake_vec,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [THREADS-1:0] mask_q,
    input logic               fifo_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R1 R2: a non-zero reply implies the count now sits one below it
    a_r2_take_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_block && rsp_data != '0) |-> (cnt_q == rsp_data - 1'b1));

    // R3: a stall only happens on an empty count
    a_r3_block_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_block |-> (rsp_data == '0 && cnt_q == '0));

    // R3: the stalled thread is now a waiter
    a_r3_block_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_block |-> mask_q[$past(req_tid)]);

    // R5: the count never wraps from its maximum to zero
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == CNT_MAX) |-> (cnt_q != '0));

    // R7: a wake pulse leaves the waiter set empty
    a_r7_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_vec != '0) |-> (mask_q == '0));

    // R8: off-mode takes return zero without stalling
    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fifo_q) && rsp_valid) |-> (rsp_data == '0 && !rsp_block));

    // R10: wake never coincides with a take response
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_vec != '0) |-> !rsp_valid);
endmodule

bind semaphore_cell semcell_checks #(
    .CNT_W(CNT_W), .THREADS(THREADS), .TID_W(TID_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_tid   (req_tid),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_block (rsp_block),
    .wake_vec  (wake_vec),
    .cnt_q     (cnt_q),
    .mask_q    (mask_q),
    .fifo_q    (fifo_q)
);

// File: tb/sim_semaphore_cell.sv
`timescale 1ns/1ps
module sim_semaphore_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_view = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_tid = '0;
    logic [15:0] req_wdata = '0;
    logic        mode_we = 1'b0;
    logic        mode_fifo = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        rsp_block;
    logic [63:0] wake_vec;

    always #2 clk = ~clk;

    semaphore_cell u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_view(req_view),
        .req_write(req_write), .req_tid(req_tid), .req_wdata(req_wdata),
        .mode_we(mode_we), .mode_fifo(mode_fifo), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_block(rsp_block), .wake_vec(wake_vec)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference model
    int          m_cnt;
    logic [63:0] m_mask;
    bit          m_off;
    bit          e_valid, e_block;
    int          e_data;
    logic [63:0] e_wake;
    string       e_tag = "R9";

    always @(posedge clk) begin
        cycles++;
        e_valid = 0; e_block = 0; e_wake = '0; e_data = 0; e_tag = "R10";
        if (!rst_n) begin
            m_cnt = 0; m_mask = '0; m_off = 0; e_tag = "R9";
        end else begin
            if (req_valid) begin
                if (m_off) begin
                    e_tag = "R8";
                    if (!req_write) e_valid = 1;
                end else if (!req_write) begin
                    e_valid = 1;
                    e_data  = m_cnt;
                    if (m_cnt > 0) begin
                        m_cnt--; e_tag = "R1/R2";
                    end else if (req_view == 1'b0) begin
                        e_block = 1; m_mask[req_tid] = 1'b1; e_tag = "R3";
                    end else begin
                        e_tag = "R4";
                    end
                end else begin
                    e_tag = "R5/R6";
                    if (m_cnt < 65535) m_cnt++;
                    if (m_mask != '0) begin
                        e_wake = m_mask; m_mask = '0; e_tag = "R7";
                    end
                end
            end
            if (mode_we) m_off = mode_fifo;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rsp_valid !== e_valid || rsp_block !== e_block || wake_vec !== e_wake ||
                (e_valid && rsp_data !== 16'(e_data))) begin
                errors++;
                $display("FAIL %s: valid=%0b block=%0b data=%h wake=%h expected valid=%0b block=%0b data=%h wake=%h",
                         e_tag, rsp_valid, rsp_block, rsp_data, wake_vec,
                         e_valid, e_block, 16'(e_data), e_wake);
            end
        end
    end

    task automatic op(input bit wr, input bit view, input int tid, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_view = view; req_tid = 6'(tid); req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic set_mode(input bit f);
        @(negedge clk);
        mode_we = 1; mode_fifo = f;
        @(negedge clk);
        mode_we = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;                       // R9 reset state compared each cycle
        repeat (3) @(negedge clk);
        op(0, 1, 2, 0);                  // R4 try on empty
        op(0, 0, 5, 0);                  // R3 stall thread 5
        op(0, 0, 63, 0);                 // R3 stall thread 63
        op(1, 0, 1, 16'hDEAD);           // R7 wake both, R6 data ignored
        op(0, 1, 0, 0);                  // R1 R2 read back 1
        op(1, 1, 3, 16'h0000);
        op(1, 0, 3, 16'hFFFF);           // R6
        op(0, 0, 9, 0);                  // R1 returns 2
        set_mode(1);                     // R8
        op(0, 0, 4, 0);
        op(1, 0, 4, 16'h1234);
        op(0, 1, 4, 0);
        set_mode(0);
        op(0, 1, 4, 0);                  // R8 count intact
        op(0, 0, 7, 0);                  // R3 waiter kept through mode
        set_mode(1);
        op(1, 0, 7, 0);                  // R8 no wake
        set_mode(0);
        op(1, 0, 7, 0);                  // R7 wake thread 7
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            req_valid = ($urandom_range(0, 3) != 0);
            req_write = ($urandom_range(0, 1) == 1);
            req_view  = ($urandom_range(0, 1) == 1);
            req_tid   = 6'($urandom);
            req_wdata = 16'($urandom);
        end
        @(negedge clk) req_valid = 0;
        for (int i = 0; i < 65540; i++) begin   // R5 saturation
            @(negedge clk);
            req_valid = 1; req_write = 1; req_wdata = 16'(i);
        end
        @(negedge clk) req_valid = 0;
        op(0, 0, 8, 0);                  // R5 reads 0xFFFF
        op(1, 0, 8, 0);
        op(0, 0, 8, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule